// File: doc/BRIEF.md
# Caption Word Readout Buffer

This block sits between a data slicer that has already recovered a 16-bit closed-caption word and a host microcontroller that collects the word over a serial link. It counts video lines from the vertical sync strobe. On line 21 it raises a one-line pulse, in even fields only or in both fields depending on a mode input. The falling edge of that pulse moves the most recent caption word into an output buffer. The host lowers its chip-select after it sees the pulse fall. It then clocks the word out least significant bit first, and the data pin is enabled only while chip-select is low.

Reading the buffer empties it. A second read in the same frame therefore returns sixteen zeros, which tells the host that no fresh word has arrived yet. While chip-select is held low the buffer is never reloaded, and a load that falls in that window is lost. The host chip-select and serial clock are asynchronous to the block clock and pass through synchronizer stages.

Top module: `cc_readout_top`

## Requirements
- R1: `line21_o` is high for exactly the line that starts with the 20th `hsync_i` strobe after a `vsync_i` strobe (line number 21, with the line after `vsync_i` counted as 1). It is low on line 20 and on line 22.
- R2: With `both_fields_i` = 0, no pulse appears while `field_even_i` = 0 (odd field).
- R3: With `both_fields_i` = 1, the pulse appears in odd and in even fields.
- R4: The word most recently captured with `cc_valid_i` enters the output buffer on the falling edge of `line21_o`. It is shifted out LSB first, and a new bit is driven after each falling edge of `sclk_i` while `cs_ni` is low.
- R5: `sdo_oe_o` is high only while the synchronized `cs_ni` is low. While it is low, `sdo_o` is 0.
- R6: A second read in the same frame returns 16 zero bits.
- R7: A load that falls while `cs_ni` is held low is dropped and not queued. The buffer contents clocked out in that same chip-select window are unchanged by it.
- R8: Each load consumes the captured word. A frame without a new `cc_valid_i` strobe loads zero.
- R9: After reset `line21_o` and `sdo_oe_o` are low and the buffer holds zero.
- R10: Raising `cs_ni` after fewer than 16 bits still empties the buffer, so the next read returns zeros.
- R11: A `cc_valid_i` strobe in the same cycle as a load is kept for the next frame. The current load takes the previously captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | One-cycle horizontal sync strobe |
| vsync_i | input | 1 | One-cycle vertical sync strobe |
| field_even_i | input | 1 | 1 = even field, 0 = odd field |
| both_fields_i | input | 1 | 1 = pulse in both fields, 0 = even fields only |
| cc_word_i | input | 16 | Caption word from the slicer |
| cc_valid_i | input | 1 | One-cycle strobe capturing `cc_word_i` |
| cs_ni | input | 1 | Host chip-select, active low, asynchronous |
| sclk_i | input | 1 | Host serial clock, asynchronous |
| line21_o | output | 1 | Line-21 pulse |
| sdo_o | output | 1 | Serial data to host |
| sdo_oe_o | output | 1 | Output enable of the data pin |

## Verification
Two events can fall in the same clock cycle: the buffer load, which is triggered by the falling edge of the line-21 pulse, and a fresh `cc_valid_i` strobe that refills the staging word. The bench times the valid strobe two clocks after the final `hsync_i` of line 21, which is the cycle the load is taken. It then reads two frames. The first read must give the older staged word and the second read must give the new one, with nothing lost or duplicated. A second pairing sets the load against a chip-select that is already low. The bench clocks out the window and expects zeros.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int unsigned CC_WORD_W     = 16;
  localparam int unsigned CC_LINE_W     = 9;
  localparam int unsigned CC_TARGET     = 21;
  localparam int unsigned CC_SYNC_DEPTH = 2;
endpackage

// File: rtl/cc_line_gen.sv
module cc_line_gen #(
  parameter int unsigned LINE_W = 9,
  parameter int unsigned TARGET = 21
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  input  logic vsync_i,
  input  logic field_even_i,
  input  logic both_fields_i,
  output logic pulse_o,
  output logic fall_o
);
  localparam logic [LINE_W-1:0] LineMax = {LINE_W{1'b1}};
  localparam logic [LINE_W-1:0] LineHit = LINE_W'(TARGET);

  logic [LINE_W-1:0] line_q;
  logic              pulse_q, pulse_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
    end else if (vsync_i) begin
      line_q <= LINE_W'(1);
    end else if (hsync_i && line_q != LineMax && line_q != '0) begin
      line_q <= line_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      pulse_d <= 1'b0;
    end else begin
      pulse_q <= (line_q == LineHit) && (field_even_i || both_fields_i);
      pulse_d <= pulse_q;
    end
  end

  assign pulse_o = pulse_q;
  assign fall_o  = pulse_d && !pulse_q;
endmodule

// File: rtl/cc_host_sync.sv
module cc_host_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  output logic cs_high_o,
  output logic cs_rise_o,
  output logic sclk_fall_o
);
  logic [DEPTH-1:0] cs_chain, ck_chain;
  logic             cs_prev, ck_prev;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cs_chain <= '1;
          ck_chain <= '1;
        end else begin
          cs_chain <= cs_ni;
          ck_chain <= sclk_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cs_chain <= '1;
          ck_chain <= '1;
        end else begin
          cs_chain <= {cs_chain[DEPTH-2:0], cs_ni};
          ck_chain <= {ck_chain[DEPTH-2:0], sclk_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev <= 1'b1;
      ck_prev <= 1'b1;
    end else begin
      cs_prev <= cs_chain[DEPTH-1];
      ck_prev <= ck_chain[DEPTH-1];
    end
  end

  assign cs_high_o   = cs_chain[DEPTH-1];
  assign cs_rise_o   = cs_chain[DEPTH-1] && !cs_prev;
  assign sclk_fall_o = ck_prev && !ck_chain[DEPTH-1];
endmodule

// File: rtl/cc_word_buf.sv
module cc_word_buf #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  input  logic              load_i,
  input  logic              cs_high_i,
  input  logic              cs_rise_i,
  input  logic              shift_i,
  output logic              bit_o,
  output logic [WORD_W-1:0] buf_o
);
  logic [WORD_W-1:0] stage_q, buf_q;
  logic              bit_q;
  logic              take;

  // load only while host is idle; otherwise the request is lost
  assign take = load_i && cs_high_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (valid_i) begin
      stage_q <= word_i;
    end else if (take) begin
      stage_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      bit_q <= 1'b0;
    end else if (take) begin
      buf_q <= stage_q;
      bit_q <= 1'b0;
    end else if (cs_rise_i) begin
      buf_q <= '0;
      bit_q <= 1'b0;
    end else if (!cs_high_i && shift_i) begin
      bit_q <= buf_q[0];
      buf_q <= buf_q >> 1;
    end
  end

  assign bit_o = bit_q;
  assign buf_o = buf_q;
endmodule

// File: rtl/cc_readout_top.sv
module cc_readout_top #(
  parameter int unsigned WORD_W     = cc_pkg::CC_WORD_W,
  parameter int unsigned LINE_W     = cc_pkg::CC_LINE_W,
  parameter int unsigned TARGET     = cc_pkg::CC_TARGET,
  parameter int unsigned SYNC_DEPTH = cc_pkg::CC_SYNC_DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              field_even_i,
  input  logic              both_fields_i,
  input  logic [WORD_W-1:0] cc_word_i,
  input  logic              cc_valid_i,
  input  logic              cs_ni,
  input  logic              sclk_i,
  output logic              line21_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic              load_stb, cs_high, cs_rise, sclk_fall, bit_w;
  logic [WORD_W-1:0] buf_word;

  cc_line_gen #(.LINE_W(LINE_W), .TARGET(TARGET)) u_line (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hsync_i      (hsync_i),
    .vsync_i      (vsync_i),
    .field_even_i (field_even_i),
    .both_fields_i(both_fields_i),
    .pulse_o      (line21_o),
    .fall_o       (load_stb)
  );

  cc_host_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .sclk_i     (sclk_i),
    .cs_high_o  (cs_high),
    .cs_rise_o  (cs_rise),
    .sclk_fall_o(sclk_fall)
  );

  cc_word_buf #(.WORD_W(WORD_W)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .word_i   (cc_word_i),
    .valid_i  (cc_valid_i),
    .load_i   (load_stb),
    .cs_high_i(cs_high),
    .cs_rise_i(cs_rise),
    .shift_i  (sclk_fall),
    .bit_o    (bit_w),
    .buf_o    (buf_word)
  );

  assign sdo_oe_o = !cs_high;
  assign sdo_o    = sdo_oe_o && bit_w;
endmodule

// File: rtl/cc_readout_chk.sv
module cc_readout_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              line21_o,
  input logic              field_even_i,
  input logic              both_fields_i,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input logic              cs_high,
  input logic              sclk_fall,
  input logic              load_stb,
  input logic [WORD_W-1:0] buf_word
);
  a_r5_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);

  a_r2_field_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line21_o) |-> ($past(field_even_i) || $past(both_fields_i)));

  a_r6_empty_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sdo_oe_o) && !load_stb) |=> (buf_word == '0));

  a_r7_hold_while_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_high && !sclk_fall) |=> $stable(buf_word));

  a_r4_lsb_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_high && sclk_fall) |=> (buf_word == ($past(buf_word) >> 1)));
endmodule

bind cc_readout_top cc_readout_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .line21_o     (line21_o),
  .field_even_i (field_even_i),
  .both_fields_i(both_fields_i),
  .sdo_o        (sdo_o),
  .sdo_oe_o     (sdo_oe_o),
  .cs_high      (cs_high),
  .sclk_fall    (sclk_fall),
  .load_stb     (load_stb),
  .buf_word     (buf_word)
);

// File: tb/cc_readout_tb.sv
module cc_readout_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hsync_i = 1'b0, vsync_i = 1'b0;
  logic        field_even_i = 1'b0, both_fields_i = 1'b0;
  logic [15:0] cc_word_i = '0;
  logic        cc_valid_i = 1'b0;
  logic        cs_ni = 1'b1, sclk_i = 1'b1;
  logic        line21_o, sdo_o, sdo_oe_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  cc_readout_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .hsync_i(hsync_i), .vsync_i(vsync_i),
    .field_even_i(field_even_i), .both_fields_i(both_fields_i),
    .cc_word_i(cc_word_i), .cc_valid_i(cc_valid_i), .cs_ni(cs_ni),
    .sclk_i(sclk_i), .line21_o(line21_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
  );

  // {both_fields, even, valid, word, expect pulse, expect read}
  typedef struct packed {
    logic        both;
    logic        even;
    logic        vld;
    logic [15:0] word;
    logic        pulse;
    logic [15:0] rd;
  } vec_t;

  localparam vec_t Vecs [6] = '{
    '{1'b0, 1'b1, 1'b1, 16'hA5C3, 1'b1, 16'hA5C3},
    '{1'b0, 1'b0, 1'b1, 16'h1234, 1'b0, 16'h0000},
    '{1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h1234},
    '{1'b1, 1'b0, 1'b1, 16'hBEEF, 1'b1, 16'hBEEF},
    '{1'b1, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h0000},
    '{1'b1, 1'b1, 1'b1, 16'h8001, 1'b1, 16'h8001}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic hpulse();
    @(negedge clk_i) hsync_i = 1'b1;
    @(negedge clk_i) hsync_i = 1'b0;
  endtask

  // vsync, optional word, lines up to 22; optional late word on the load cycle
  task automatic frame(input logic both, input logic even, input logic vld,
                       input logic [15:0] w, input logic exp_pulse,
                       input logic late, input logic [15:0] lw);
    both_fields_i = both;
    field_even_i  = even;
    @(negedge clk_i) vsync_i = 1'b1;
    @(negedge clk_i) vsync_i = 1'b0;
    if (vld) begin
      @(negedge clk_i) begin cc_valid_i = 1'b1; cc_word_i = w; end
      @(negedge clk_i) cc_valid_i = 1'b0;
    end
    for (int i = 0; i < 19; i++) hpulse();
    wait_n(3);
    check("R1 line20 low", {15'd0, line21_o}, 16'd0);
    hpulse();
    wait_n(2);
    check(both ? "R3 pulse" : (even ? "R1 pulse" : "R2 odd no pulse"),
          {15'd0, line21_o}, {15'd0, exp_pulse});
    hpulse();
    if (late) begin
      @(negedge clk_i) begin cc_valid_i = 1'b1; cc_word_i = lw; end
      @(negedge clk_i) cc_valid_i = 1'b0;
    end
    wait_n(3);
    check("R1 line22 low", {15'd0, line21_o}, 16'd0);
  endtask

  task automatic clock_bits(input int n, output logic [15:0] bits);
    bits = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) sclk_i = 1'b0;
      wait_n(4);
      bits[i] = sdo_o;
      sclk_i = 1'b1;
      wait_n(4);
    end
  endtask

  task automatic read_word(input int n, output logic [15:0] bits);
    @(negedge clk_i) cs_ni = 1'b0;
    wait_n(4);
    check("R5 oe while selected", {15'd0, sdo_oe_o}, 16'd1);
    clock_bits(n, bits);
    cs_ni = 1'b1;
    wait_n(5);
    check("R5 oe off", {15'd0, sdo_oe_o}, 16'd0);
    check("R5 data low when off", {15'd0, sdo_o}, 16'd0);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk_i);
      wd++;
      if (wd > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<=%0d", wd, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] rd;
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(2);
    // R9 reset state
    check("R9 line21 low", {15'd0, line21_o}, 16'd0);
    check("R9 oe low", {15'd0, sdo_oe_o}, 16'd0);
    read_word(16, rd);
    check("R9 buffer zero", rd, 16'h0000);

    // R4/R8 table walk
    for (int v = 0; v < 6; v++) begin
      frame(Vecs[v].both, Vecs[v].even, Vecs[v].vld, Vecs[v].word, Vecs[v].pulse, 1'b0, '0);
      read_word(16, rd);
      check(v == 4 ? "R8 empty frame loads zero" : "R4 word readout", rd, Vecs[v].rd);
    end

    // R6 second read in the same frame
    read_word(16, rd);
    check("R6 second read zero", rd, 16'h0000);

    // R10 partial read then full read
    frame(1'b0, 1'b1, 1'b1, 16'h0F0F, 1'b1, 1'b0, '0);
    read_word(5, rd);
    check("R10 partial bits", rd, 16'h000F);
    read_word(16, rd);
    check("R10 read after partial zero", rd, 16'h0000);

    // R11 valid strobe in the load cycle
    frame(1'b0, 1'b1, 1'b1, 16'h3C3C, 1'b1, 1'b1, 16'hC00D);
    read_word(16, rd);
    check("R11 load takes older word", rd, 16'h3C3C);
    frame(1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, '0);
    read_word(16, rd);
    check("R11 late word kept", rd, 16'hC00D);

    // R7 load while selected is dropped
    @(negedge clk_i) cs_ni = 1'b0;
    wait_n(4);
    frame(1'b1, 1'b1, 1'b1, 16'h7777, 1'b1, 1'b0, '0);
    clock_bits(16, rd);
    check("R7 dropped load", rd, 16'h0000);
    cs_ni = 1'b1;
    wait_n(5);
    check("R5 oe off after R7", {15'd0, sdo_oe_o}, 16'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule